// File: doc/BRIEF.md
# Width-Configurable Ternary Match Array

This block is a ternary lookup array made of fixed 48-bit storage slices. Each slice holds a 48-bit value, a 48-bit care mask, a valid bit and a 32-bit associated-data word. A search request carries a key of up to 576 bits and a mode code. The mode code picks how many adjacent slices form one logical entry, so the same storage serves as many narrow entries or as fewer wide ones. The total capacity does not change.

Each search compares the key against every logical entry of the requested width in parallel. It returns a hit flag, the index of the lowest-numbered matching entry, and the associated data of that entry. The associated data is made by joining the data words of the entry's slices, so its width grows with the key width. Searches are pipelined and accepted every clock whatever the width. Each search carries its own mode, so widths may be mixed freely from one cycle to the next. A separate write port loads one slice per cycle.

Top module: `tmatch_array`

## Requirements
- R1: The mode code sets the slice count k per logical entry: 0→1 (48-bit key), 1→2 (96), 2→3 (144), 3→4 (192), 4→6 (288), 5→12 (576). Codes 6 and 7 behave exactly as code 0. The array holds NUM_SLICES/k logical entries.
- R2: A care-mask bit of 1 compares the stored value bit with the key bit. A care bit of 0 matches either key value.
- R3: Logical entry n uses slices n*k through n*k+k-1. Key bits [j*48 +: 48] are compared against slice n*k+j. The entry matches only if all k of its slices match. A key that lines up with slices across an entry boundary does not match.
- R4: A slice written with the valid input low never matches, so no entry that contains it matches. Reset clears every valid bit.
- R5: When several entries match, the lowest index is reported. On a miss, res_hit, res_idx and res_data are all zero.
- R6: On a hit, res_data[j*32 +: 32] holds the data word of slice n*k+j for j < k. All higher bits of res_data are zero.
- R7: A search sampled at clock edge e produces its result on the outputs after edge e+2, with res_vld high. One search is accepted on every edge in every mode. res_vld is low in cycles with no search, and the other outputs are then zero.
- R8: A write sampled at edge e is seen by searches sampled at edge e+1 or later, and not by a search sampled at edge e. This holds for the value, the mask, the valid bit and the associated data alike, even when the data write arrives after the search.
- R9: Synchronous active-high reset clears all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one slice this cycle |
| wr_slice | input | SIDX_W | Slice number to write |
| wr_value | input | 48 | Stored value bits |
| wr_care | input | 48 | Care mask, 1 = compare |
| wr_valid | input | 1 | Valid bit for the slice |
| wr_data | input | 32 | Associated-data word for the slice |
| srch_vld | input | 1 | Search request present |
| srch_mode | input | 3 | Key-width mode code |
| srch_key | input | 576 | Search key, lane j in bits [j*48 +: 48] |
| res_vld | output | 1 | Result valid |
| res_hit | output | 1 | Some entry matched |
| res_idx | output | IDX_W | Index of winning logical entry |
| res_data | output | 384 | Joined associated data of the winner |

## Verification
The case hardest to reach from the ports is a write that lands while a search is still in flight. In particular, a data rewrite to the slice a search has just matched must not show up in that search's result. The stimulus issues a search and, on the very next cycle, rewrites that slice's data word. It also issues a write and a search on the same cycle. Both cases are checked against a reference model that takes a snapshot of the table as each search is issued. Keys built to straddle an entry boundary in the wider modes, and searches whose mode changes every cycle, cover the slice-ganging rules.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;
  localparam int SLICE_W  = 48;
  localparam int DATA_W   = 32;
  localparam int MAX_GANG = 12;
  localparam int MODE_W   = 3;
  localparam int N_VAR    = 6;
  localparam int KEY_W    = SLICE_W * MAX_GANG;
  localparam int WORD_W   = DATA_W * MAX_GANG;

  // slices per logical entry for a width variant
  function automatic int var_gang(input int v);
    case (v)
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 6;
      5: return 12;
      default: return 1;
    endcase
  endfunction

  // width variant selected by a mode code (unused codes fall back to 0)
  function automatic int mode_var(input logic [MODE_W-1:0] m);
    return (int'(m) < N_VAR) ? int'(m) : 0;
  endfunction

  function automatic int mode_gang(input logic [MODE_W-1:0] m);
    return var_gang(mode_var(m));
  endfunction
endpackage

// File: rtl/tmatch_slices.sv
module tmatch_slices
  import tmatch_pkg::*;
#(
  parameter int NUM_SLICES = 24,
  localparam int SIDX_W = $clog2(NUM_SLICES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SIDX_W-1:0]     wr_slice,
  input  logic [SLICE_W-1:0]    wr_value,
  input  logic [SLICE_W-1:0]    wr_care,
  input  logic                  wr_valid,
  input  logic [MODE_W-1:0]     srch_mode,
  input  logic [KEY_W-1:0]      srch_key,
  output logic [NUM_SLICES-1:0] slice_hit
);
  logic [SLICE_W-1:0]    val_q  [NUM_SLICES];
  logic [SLICE_W-1:0]    care_q [NUM_SLICES];
  logic [NUM_SLICES-1:0] live_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      val_q[wr_slice]  <= wr_value;
      care_q[wr_slice] <= wr_care;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else if (wr_en) live_q[wr_slice] <= wr_valid;
  end

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_cmp
    logic [SLICE_W-1:0] lane_key;
    always_comb begin
      lane_key = srch_key[(s % mode_gang(srch_mode)) * SLICE_W +: SLICE_W];
      slice_hit[s] = live_q[s] && (((lane_key ^ val_q[s]) & care_q[s]) == '0);
    end
  end
endmodule

// File: rtl/tmatch_prio.sv
module tmatch_prio #(
  parameter int NUM_SLICES = 24,
  parameter int GANG       = 1,
  parameter int IDX_W      = 5
) (
  input  logic [NUM_SLICES-1:0] slice_hit,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx
);
  localparam int ENTRIES = NUM_SLICES / GANG;

  logic [ENTRIES-1:0] entry_hit;

  for (genvar n = 0; n < ENTRIES; n++) begin : g_ent
    assign entry_hit[n] = &slice_hit[n*GANG +: GANG];
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int n = ENTRIES - 1; n >= 0; n--) begin
      if (entry_hit[n]) begin
        hit = 1'b1;
        idx = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/tmatch_adata.sv
module tmatch_adata
  import tmatch_pkg::*;
#(
  parameter int NUM_SLICES = 24,
  parameter int WR_LAG     = 2,
  localparam int SIDX_W = $clog2(NUM_SLICES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SIDX_W-1:0]  wr_slice,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic               rd_hit,
  input  logic [SIDX_W-1:0]  rd_idx,
  input  logic [MODE_W-1:0]  rd_mode,
  output logic [WORD_W-1:0]  rd_word
);
  logic [DATA_W-1:0] mem [NUM_SLICES];

  // delay writes so they line up with the read stage of the search pipe
  logic              lag_en   [WR_LAG];
  logic [SIDX_W-1:0] lag_slot [WR_LAG];
  logic [DATA_W-1:0] lag_dat  [WR_LAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WR_LAG; i++) lag_en[i] <= 1'b0;
    end else begin
      lag_en[0] <= wr_en;
      for (int i = 1; i < WR_LAG; i++) lag_en[i] <= lag_en[i-1];
    end
  end

  always_ff @(posedge clk) begin
    lag_slot[0] <= wr_slice;
    lag_dat[0]  <= wr_data;
    for (int i = 1; i < WR_LAG; i++) begin
      lag_slot[i] <= lag_slot[i-1];
      lag_dat[i]  <= lag_dat[i-1];
    end
    if (lag_en[WR_LAG-1]) mem[lag_slot[WR_LAG-1]] <= lag_dat[WR_LAG-1];
  end

  logic [WORD_W-1:0] word;
  always_comb begin
    int k;
    int base;
    k    = mode_gang(rd_mode);
    base = int'(rd_idx) * k;
    word = '0;
    if (rd_en && rd_hit) begin
      for (int j = 0; j < MAX_GANG; j++) begin
        if (j < k && (base + j) < NUM_SLICES) word[j*DATA_W +: DATA_W] = mem[base + j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_word <= '0;
    else     rd_word <= word;
  end
endmodule

// File: rtl/tmatch_array.sv
module tmatch_array
  import tmatch_pkg::*;
#(
  parameter int NUM_SLICES = 24,
  localparam int SIDX_W = $clog2(NUM_SLICES),
  localparam int IDX_W  = SIDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SIDX_W-1:0]   wr_slice,
  input  logic [SLICE_W-1:0]  wr_value,
  input  logic [SLICE_W-1:0]  wr_care,
  input  logic                wr_valid,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                srch_vld,
  input  logic [MODE_W-1:0]   srch_mode,
  input  logic [KEY_W-1:0]    srch_key,
  output logic                res_vld,
  output logic                res_hit,
  output logic [IDX_W-1:0]    res_idx,
  output logic [WORD_W-1:0]   res_data
);
  localparam int PIPE = 3;

  // stage 1: per-slice compare
  logic [NUM_SLICES-1:0] cmp_hit;
  logic [NUM_SLICES-1:0] s1_hit;
  logic                  s1_vld;
  logic [MODE_W-1:0]     s1_mode;

  tmatch_slices #(.NUM_SLICES(NUM_SLICES)) u_slices (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slice(wr_slice),
    .wr_value(wr_value), .wr_care(wr_care), .wr_valid(wr_valid),
    .srch_mode(srch_mode), .srch_key(srch_key), .slice_hit(cmp_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_hit  <= '0;
      s1_mode <= '0;
    end else begin
      s1_vld  <= srch_vld;
      s1_hit  <= srch_vld ? cmp_hit : '0;
      s1_mode <= srch_mode;
    end
  end

  // stage 2: gang slices per width variant and pick lowest index
  logic [N_VAR-1:0] v_hit;
  logic [IDX_W-1:0] v_idx [N_VAR];

  for (genvar v = 0; v < N_VAR; v++) begin : g_var
    tmatch_prio #(.NUM_SLICES(NUM_SLICES), .GANG(var_gang(v)), .IDX_W(IDX_W)) u_prio (
      .slice_hit(s1_hit), .hit(v_hit[v]), .idx(v_idx[v])
    );
  end

  logic             s2_vld, s2_hit;
  logic [IDX_W-1:0] s2_idx;
  logic [MODE_W-1:0] s2_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_hit  <= 1'b0;
      s2_idx  <= '0;
      s2_mode <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_hit  <= s1_vld && v_hit[mode_var(s1_mode)];
      s2_idx  <= (s1_vld && v_hit[mode_var(s1_mode)]) ? v_idx[mode_var(s1_mode)] : '0;
      s2_mode <= s1_mode;
    end
  end

  // stage 3: associated-data read and result registers
  tmatch_adata #(.NUM_SLICES(NUM_SLICES), .WR_LAG(PIPE - 1)) u_adata (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slice(wr_slice), .wr_data(wr_data),
    .rd_en(s2_vld), .rd_hit(s2_hit), .rd_idx(s2_idx), .rd_mode(s2_mode),
    .rd_word(res_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_hit <= 1'b0;
      res_idx <= '0;
    end else begin
      res_vld <= s2_vld;
      res_hit <= s2_hit;
      res_idx <= s2_idx;
    end
  end
endmodule

// File: rtl/tmatch_array_chk.sv
module tmatch_array_chk
  import tmatch_pkg::*;
#(
  parameter int NUM_SLICES = 24,
  localparam int IDX_W = $clog2(NUM_SLICES)
) (
  input logic                clk,
  input logic                rst,
  input logic                srch_vld,
  input logic [MODE_W-1:0]   srch_mode,
  input logic                res_vld,
  input logic                res_hit,
  input logic [IDX_W-1:0]    res_idx,
  input logic [WORD_W-1:0]   res_data
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  function automatic logic [WORD_W-1:0] low_mask(input logic [MODE_W-1:0] m);
    logic [WORD_W-1:0] msk;
    msk = '0;
    for (int j = 0; j < MAX_GANG; j++) if (j < mode_gang(m)) msk[j*DATA_W +: DATA_W] = '1;
    return msk;
  endfunction

  // R7: result follows the request three edges later
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (res_vld == $past(srch_vld, 3)));

  // R7: idle cycles carry zeros
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> (!res_hit && res_idx == '0 && res_data == '0));

  // R5: a miss reports index and data zero
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_hit) |-> (res_idx == '0 && res_data == '0));

  // R3: winning index lies inside the entry count of the search's mode
  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && res_hit) |->
      (int'(res_idx) < NUM_SLICES / mode_gang($past(srch_mode, 3))));

  // R6: data lanes above the entry's slice count are zero
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && res_hit) |->
      ((res_data & ~low_mask($past(srch_mode, 3))) == '0));
endmodule

bind tmatch_array tmatch_array_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
  .clk(clk), .rst(rst), .srch_vld(srch_vld), .srch_mode(srch_mode),
  .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_data(res_data)
);

// File: tb/sim_tmatch_array.sv
module sim_tmatch_array;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 24;
  localparam int IW  = $clog2(NS);
  localparam int SW  = 48;
  localparam int DW  = 32;
  localparam int KW  = 576;
  localparam int OW  = 384;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, wr_valid, srch_vld;
  logic [IW-1:0] wr_slice;
  logic [SW-1:0] wr_value, wr_care;
  logic [DW-1:0] wr_data;
  logic [2:0]    srch_mode;
  logic [KW-1:0] srch_key;
  logic          res_vld, res_hit;
  logic [IW-1:0] res_idx;
  logic [OW-1:0] res_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmatch_array #(.NUM_SLICES(NS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slice(wr_slice), .wr_value(wr_value),
    .wr_care(wr_care), .wr_valid(wr_valid), .wr_data(wr_data), .srch_vld(srch_vld),
    .srch_mode(srch_mode), .srch_key(srch_key), .res_vld(res_vld), .res_hit(res_hit),
    .res_idx(res_idx), .res_data(res_data)
  );

  // reference model state
  logic [SW-1:0] m_val [NS];
  logic [SW-1:0] m_care[NS];
  bit            m_live[NS];
  logic [DW-1:0] m_dat [NS];
  bit            p_vld[3], p_hit[3];
  int            p_idx[3];
  logic [OW-1:0] p_dat[3];

  int    vectors = 0, errors = 0;
  string cur_req = "R9";
  bit    done = 0;

  function automatic int gang(input logic [2:0] m);
    case (m)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 6;
      3'd5: return 12;
      default: return 1;
    endcase
  endfunction

  task automatic model_search(output bit h, output int ix, output logic [OW-1:0] d);
    int k = gang(srch_mode);
    h = 0; ix = 0; d = '0;
    for (int n = 0; n < NS / k && !h; n++) begin
      bit ok = 1;
      for (int j = 0; j < k; j++) begin
        int s = n*k + j;
        if (!m_live[s] || (((srch_key[j*SW +: SW] ^ m_val[s]) & m_care[s]) != '0)) ok = 0;
      end
      if (ok) begin
        h = 1; ix = n;
        for (int j = 0; j < k; j++) d[j*DW +: DW] = m_dat[n*k + j];
      end
    end
  endtask

  task automatic step();
    bit h; int ix; logic [OW-1:0] d;
    model_search(h, ix, d);
    if (rst) begin
      for (int i = 0; i < 3; i++) begin p_vld[i] = 0; p_hit[i] = 0; p_idx[i] = 0; p_dat[i] = '0; end
      for (int s = 0; s < NS; s++) m_live[s] = 0;
    end else begin
      for (int i = 2; i > 0; i--) begin
        p_vld[i] = p_vld[i-1]; p_hit[i] = p_hit[i-1]; p_idx[i] = p_idx[i-1]; p_dat[i] = p_dat[i-1];
      end
      p_vld[0] = srch_vld;
      p_hit[0] = srch_vld && h;
      p_idx[0] = srch_vld ? ix : 0;
      p_dat[0] = srch_vld ? d : '0;
      if (wr_en) begin
        m_val[wr_slice] = wr_value; m_care[wr_slice] = wr_care;
        m_live[wr_slice] = wr_valid; m_dat[wr_slice] = wr_data;
      end
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (res_vld !== p_vld[2] || res_hit !== p_hit[2] || res_idx !== IW'(p_idx[2]) || res_data !== p_dat[2]) begin
      errors++;
      $display("FAIL %s: vld/hit/idx %0b/%0b/%0d data %h, expected %0b/%0b/%0d data %h",
               cur_req, res_vld, res_hit, res_idx, res_data, p_vld[2], p_hit[2], p_idx[2], p_dat[2]);
    end
    wr_en = 0; srch_vld = 0;
  endtask

  task automatic put(input int s, input logic [SW-1:0] v, input logic [SW-1:0] c,
                     input bit live, input logic [DW-1:0] d);
    wr_en = 1; wr_slice = IW'(s); wr_value = v; wr_care = c; wr_valid = live; wr_data = d;
  endtask

  task automatic ask(input logic [2:0] m, input logic [KW-1:0] k);
    srch_vld = 1; srch_mode = m; srch_key = k;
  endtask

  function automatic logic [SW-1:0] base_val(input int s);
    return 48'hA5C3_0000_0000 | SW'(s * 17 + 3);
  endfunction

  // key whose lanes copy the model values of slices first..first+k-1
  function automatic logic [KW-1:0] key_of(input int first, input int k);
    logic [KW-1:0] key = '0;
    for (int j = 0; j < k; j++) key[j*SW +: SW] = m_val[first + j];
    return key;
  endfunction

  task automatic flush();
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; srch_vld = 0; wr_slice = '0; wr_value = '0; wr_care = '0;
    wr_valid = 0; wr_data = '0; srch_mode = '0; srch_key = '0;
    for (int s = 0; s < NS; s++) begin m_val[s] = '0; m_care[s] = '0; m_dat[s] = '0; m_live[s] = 0; end
    @(negedge clk);
    // R9: reset clears outputs
    cur_req = "R9";
    for (int i = 0; i < 3; i++) step();
    rst = 0;
    ask(3'd0, '0); step();          // R4: empty array misses
    cur_req = "R4"; flush();

    // load every slice with a distinct value, full care
    cur_req = "R1";
    for (int s = 0; s < NS; s++) begin put(s, base_val(s), '1, 1, 32'hD000_0000 + 32'(s)); step(); end

    // R1 / R3: 48-bit mode exact match
    cur_req = "R1"; ask(3'd0, key_of(5, 1)); step(); flush();

    // R2: slice 3 ignores its low byte; key of slice 5 variant hits 3 first (R5 lowest index)
    cur_req = "R2";
    put(3, base_val(3), 48'hFFFF_FFFF_FF00, 1, 32'h3333_0003); step();
    ask(3'd0, {528'h0, base_val(3) ^ 48'h0000_0000_005A}); step();
    cur_req = "R5"; ask(3'd0, key_of(5, 1) & ~48'h0); step(); flush();

    // R4: invalidating slice 3 turns the masked hit into a miss
    cur_req = "R4";
    put(3, base_val(3), 48'hFFFF_FFFF_FF00, 0, 32'h3333_0003); step();
    ask(3'd0, {528'h0, base_val(3) ^ 48'h0000_0000_005A}); step(); flush();

    // R8: write and search on the same edge see the old state; next edge sees the new
    cur_req = "R8";
    put(7, base_val(7), '1, 0, 32'h7777_0007); ask(3'd0, key_of(7, 1)); step();
    ask(3'd0, key_of(7, 1)); step();
    // R8: data rewrite one cycle after a search does not leak into its result
    ask(3'd0, key_of(9, 1)); step();
    put(9, base_val(9), '1, 1, 32'hBEEF_0009); step();
    ask(3'd0, key_of(9, 1)); step(); flush();

    // restore slices 3 and 7
    put(3, base_val(3), '1, 1, 32'hD000_0003); step();
    put(7, base_val(7), '1, 1, 32'hD000_0007); step();

    // R3 / R6: 96-bit mode, entry 4 = slices 8,9; boundary-straddling key misses
    cur_req = "R6"; ask(3'd1, key_of(8, 2)); step();
    cur_req = "R3"; ask(3'd1, key_of(9, 2)); step(); flush();

    // R1 / R6: every mode finds the entry starting at slice 12
    cur_req = "R1";
    ask(3'd2, key_of(12, 3));  step();
    ask(3'd3, key_of(12, 4));  step();
    ask(3'd4, key_of(12, 6));  step();
    cur_req = "R6"; ask(3'd5, key_of(12, 12)); step();
    cur_req = "R1"; ask(3'd6, key_of(12, 1));  step();
    ask(3'd7, key_of(20, 1));  step(); flush();

    // R7: back-to-back searches with the mode changing each cycle
    cur_req = "R7";
    for (int i = 0; i < 24; i++) begin
      logic [2:0] m = 3'(i % 8);
      int k = gang(m);
      int first = ((i * 5) % (NS / k)) * k;
      ask(m, (i % 3 == 2) ? key_of(first, k) ^ 576'h1 : key_of(first, k));
      step();
    end
    flush();

    // R2: an all-don't-care slice 0 matches any key, winning by lowest index (R5)
    cur_req = "R2";
    put(0, 48'h0, 48'h0, 1, 32'hCAFE_0000); step();
    ask(3'd0, {528'h0, 48'h1234_5678_9ABC}); step();
    cur_req = "R5"; ask(3'd0, key_of(11, 1)); step(); flush();

    // R9: reset in the middle of traffic
    cur_req = "R9";
    ask(3'd0, key_of(4, 1)); step();
    rst = 1; step(); rst = 0;
    ask(3'd0, key_of(4, 1)); step(); flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule